// File: doc/BRIEF.md
# Shared-Logic Carry-Select Ripple Adder

This block is a purely combinational adder of parameterised width. It is meant to be the ripple section inside a larger carry-skip adder. Each bit position prepares two candidate results before the real carry reaches it.

The first candidate assumes a carry-in of zero and comes from the bit's half-adder signals. The second candidate assumes a carry-in of one. It is built by reusing those same half-adder signals, with one inverter for the sum and one OR gate for the carry, so no second adder is needed. A 2:1 selector, steered by the carry that actually arrives at the bit, chooses between the two candidates. The carry it selects then steers the next bit up. The carry selected at the top bit leaves the block as the carry-out.

A user connects the two operands and the carry-in. After the combinational settling time, the sum and carry-out appear. There is no clock, no reset and no state.

Top module: `cbl_adder`

## Requirements
- R1: For every pair of WIDTH-bit operands and either carry-in, {carryOut, sumOut} equals opA + opB + carryIn as an unsigned (WIDTH+1)-bit value.
- R2: At each bit, the carry-in-zero candidate has sum = a XOR b and carry = a AND b. It is chosen when the carry entering that bit is 0. For example, with carryIn = 0 and WIDTH = 4, opA = 0001 and opB = 0001 give sumOut = 0010 and carryOut = 0.
- R3: At each bit, the carry-in-one candidate has sum = NOT(a XOR b) and carry = a OR b. It is chosen when the carry entering that bit is 1. For example, with carryIn = 1 and WIDTH = 4, opA = 0000 and opB = 0000 give sumOut = 0001.
- R4: Bit 0 is steered by carryIn. Each higher bit i is steered by the carry selected at bit i-1. A carry therefore travels through a run of propagate bits: with WIDTH = 4, opA = 0111, opB = 0000 and carryIn = 1 give sumOut = 1000 and carryOut = 0.
- R5: carryOut is the carry selected at the most significant bit. With WIDTH = 4, opA = 1111, opB = 0000 and carryIn = 1 give sumOut = 0000 and carryOut = 1. Operands 1111 and 1111 with carryIn = 1 give sumOut = 1111 and carryOut = 1.
- R6: Zero operands with carryIn = 0 give sumOut = 0 and carryOut = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | WIDTH | Sum bits |
| carryOut | output | 1 | Carry out of the top bit |

## Verification
At four bits, every operand pair is tried with both carry-in values. This exhaustive sweep separates a wrong candidate in either half of any cell from a wrong select. At sixteen bits, a table of directed vectors covers the carry chain:
- alternating patterns, which propagate in every bit;
- all-ones with a carry, which ripples across the full width;
- a top-bit generate, which sets the carry-out only;
- a carry that stops mid-word.

Random sixteen-bit vectors follow. Single-bit directed cases then confirm which candidate each carry value selects.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
  // Candidate results of one bit, for each assumed incoming carry.
  typedef struct packed {
    logic sum0;
    logic carry0;
    logic sum1;
    logic carry1;
  } bitCand_t;
endpackage

// File: rtl/cbl_cand_cell.sv
module cbl_cand_cell
  import cbl_pkg::*;
(
  input  logic     bitA,
  input  logic     bitB,
  output bitCand_t cand
);
  logic halfSum;
  logic halfGen;

  // Half-adder: the carry-in-zero path.
  assign halfSum = bitA ^ bitB;
  assign halfGen = bitA & bitB;

  // Shared logic for carry-in one: one inverter and one OR gate.
  assign cand.sum0   = halfSum;
  assign cand.carry0 = halfGen;
  assign cand.sum1   = ~halfSum;
  assign cand.carry1 = bitA | bitB;

  always_comb begin
    assert_cin0_cand_R2: assert ({cand.carry0, cand.sum0} == 2'(bitA) + 2'(bitB))
      else $error("carry-in-zero candidate wrong");
    assert_cin1_cand_R3: assert ({cand.carry1, cand.sum1} == 2'(bitA) + 2'(bitB) + 2'd1)
      else $error("carry-in-one candidate wrong");
  end
endmodule

// File: rtl/cbl_cand_gen.sv
module cbl_cand_gen
  import cbl_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                  [WIDTH-1:0] opA,
  input  logic                  [WIDTH-1:0] opB,
  output bitCand_t [WIDTH-1:0]              candVec
);
  for (genvar gi = 0; gi < WIDTH; gi++) begin : gCell
    cbl_cand_cell cell_i (
      .bitA (opA[gi]),
      .bitB (opB[gi]),
      .cand (candVec[gi])
    );
  end
endmodule

// File: rtl/cbl_select_chain.sv
module cbl_select_chain
  import cbl_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  bitCand_t [WIDTH-1:0]              candVec,
  input  logic                              carryIn,
  output logic                  [WIDTH-1:0] sumOut,
  output logic                              carryOut
);
  localparam int CHAIN = WIDTH + 1;

  logic [CHAIN-1:0] carryVec;

  assign carryVec[0] = carryIn;

  for (genvar gi = 0; gi < WIDTH; gi++) begin : gSel
    assign sumOut[gi]     = carryVec[gi] ? candVec[gi].sum1   : candVec[gi].sum0;
    assign carryVec[gi+1] = carryVec[gi] ? candVec[gi].carry1 : candVec[gi].carry0;

    // A generating bit always carries out; a killing bit never does (R4).
    always_comb begin
      assert_sel_bounds_R4: assert (!(candVec[gi].carry0 && !carryVec[gi+1]) &&
                                    !(!candVec[gi].carry1 && carryVec[gi+1]))
        else $error("selected carry outside candidate bounds at bit %0d", gi);
    end
  end

  assign carryOut = carryVec[CHAIN-1];
endmodule

// File: rtl/cbl_adder.sv
module cbl_adder
  import cbl_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  localparam int RES_W = WIDTH + 1;

  bitCand_t [WIDTH-1:0] candVec;

  cbl_cand_gen #(.WIDTH(WIDTH)) gen_i (
    .opA     (opA),
    .opB     (opB),
    .candVec (candVec)
  );

  cbl_select_chain #(.WIDTH(WIDTH)) chain_i (
    .candVec  (candVec),
    .carryIn  (carryIn),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );

  always_comb begin
    assert_total_sum_R1: assert ({carryOut, sumOut} ==
                                 RES_W'(opA) + RES_W'(opB) + RES_W'(carryIn))
      else $error("adder result mismatch");
  end
endmodule

// File: tb/cbl_adder_tb_top.sv
module cbl_adder_tb_top;
  localparam int WIDE = 16;
  localparam int NARROW = 4;
  localparam int NVEC = 9;
  localparam int NRAND = 2000;

  // {a, b, cin, expected {carryOut, sumOut}}
  localparam logic [49:0] VEC_TAB [NVEC] = '{
    {16'h0000, 16'h0000, 1'b0, 17'h00000},
    {16'hFFFF, 16'h0001, 1'b0, 17'h10000},
    {16'hFFFF, 16'h0000, 1'b1, 17'h10000},
    {16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF},
    {16'hAAAA, 16'h5555, 1'b0, 17'h0FFFF},
    {16'hAAAA, 16'h5555, 1'b1, 17'h10000},
    {16'h1234, 16'h4321, 1'b0, 17'h05555},
    {16'h8000, 16'h8000, 1'b0, 17'h10000},
    {16'h7FFF, 16'h0001, 1'b0, 17'h08000}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [WIDE-1:0]   wA = '0, wB = '0, wSum;
  logic              wCin = 1'b0, wCout;
  logic [NARROW-1:0] nA = '0, nB = '0, nSum;
  logic              nCin = 1'b0, nCout;

  int checks = 0;
  int errors = 0;

  cbl_adder #(.WIDTH(WIDE)) dut_i (
    .opA(wA), .opB(wB), .carryIn(wCin), .sumOut(wSum), .carryOut(wCout)
  );

  cbl_adder #(.WIDTH(NARROW)) dut_n_i (
    .opA(nA), .opB(nB), .carryIn(nCin), .sumOut(nSum), .carryOut(nCout)
  );

  task automatic checkWide(input logic [15:0] a, input logic [15:0] b,
                           input logic c, input logic [16:0] exp, input string req);
    @(posedge clk); wA = a; wB = b; wCin = c;
    @(negedge clk);
    checks++;
    if ({wCout, wSum} !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h cin=%0d got=%h exp=%h", req, a, b, c, {wCout, wSum}, exp);
    end
  endtask

  task automatic checkNarrow(input logic [3:0] a, input logic [3:0] b,
                             input logic c, input logic [4:0] exp, input string req);
    @(posedge clk); nA = a; nB = b; nCin = c;
    @(negedge clk);
    checks++;
    if ({nCout, nSum} !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h cin=%0d got=%h exp=%h", req, a, b, c, {nCout, nSum}, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R6: all-zero inputs.
    checkWide(16'h0, 16'h0, 1'b0, 17'h0, "R6");
    checkNarrow(4'h0, 4'h0, 1'b0, 5'h0, "R6");

    // R1: directed vector table, 16 bits.
    for (int i = 0; i < NVEC; i++)
      checkWide(VEC_TAB[i][49:34], VEC_TAB[i][33:18], VEC_TAB[i][17], VEC_TAB[i][16:0], "R1");

    // R1: exhaustive 4-bit sweep.
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 2; c++)
          checkNarrow(4'(a), 4'(b), 1'(c), 5'(a) + 5'(b) + 5'(c), "R1");

    // R1: random 16-bit vectors.
    for (int k = 0; k < NRAND; k++) begin
      logic [15:0] ra, rb;
      logic rc;
      ra = 16'($urandom);
      rb = 16'($urandom);
      rc = 1'($urandom);
      checkWide(ra, rb, rc, 17'(ra) + 17'(rb) + 17'(rc), "R1");
    end

    // R2: carry-in-zero candidate chosen.
    checkNarrow(4'b0001, 4'b0001, 1'b0, 5'b00010, "R2");
    checkNarrow(4'b0001, 4'b0000, 1'b0, 5'b00001, "R2");
    // R3: carry-in-one candidate chosen.
    checkNarrow(4'b0000, 4'b0000, 1'b1, 5'b00001, "R3");
    checkNarrow(4'b0001, 4'b0000, 1'b1, 5'b00010, "R3");
    // R4: carry travels through propagate bits and stops at a kill.
    checkNarrow(4'b0111, 4'b0000, 1'b1, 5'b01000, "R4");
    checkNarrow(4'b0101, 4'b0010, 1'b1, 5'b01000, "R4");
    // R5: carry-out from the top bit.
    checkNarrow(4'b1111, 4'b0000, 1'b1, 5'b10000, "R5");
    checkNarrow(4'b1111, 4'b1111, 1'b1, 5'b11111, "R5");
    checkNarrow(4'b1000, 4'b1000, 1'b0, 5'b10000, "R5");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule